// File: doc/BRIEF.md
# Double-Buffered Packet DMA Channel

This block serves one data source. It writes the source's stream of words into a packet buffer in memory, one word after another from the buffer's start address. The buffer has a fixed size. Software sets the channel up through a small register port and loads a shadow start address while the current buffer is still filling. When the chosen synchronisation event arrives, either a time tick or a spin-phase pulse, the shadow address becomes the active address. The write pointer then starts again at the new buffer's first word. No incoming word is lost at the switch.

Each swap raises a one-cycle interrupt. Software then has one packet period to load the next shadow address. If an event finds no shadow address loaded, the channel keeps filling its current buffer and sets a sticky overrun flag. A channel marked slow swaps only when software has armed it before the event. A full buffer takes no further words. Those words are dropped and counted instead. After each swap, the byte count of the buffer just finished can be read back.

Top module: `pkt_dma_chan`

## Requirements
- R1: After reset the channel is disabled. CTRL, STATUS and ACTIVE read zero, `irq` is low, and `mem_we` stays low even when `din_valid` is high.
- R2: When the channel is enabled, `din_valid` is high and the buffer is not full, `mem_we` goes high in the same cycle. `mem_addr` equals the active address plus 4 times the word index, and `mem_wdata` equals `din_data`. Enabling a disabled channel restarts the word index at 0.
- R3: The host writes through `host_wr`, `host_addr` and `host_wdata`, and `host_rdata` reflects `host_addr` in the same cycle. The register map is: 0 CTRL, 1 SHADOW, 2 ARM, 3 STATUS, 4 LAST_BYTES, 5 DROPS, 6 ACTIVE. A SHADOW write while enabled stores the shadow address, sets STATUS bit 0 (valid) and leaves ACTIVE unchanged. A SHADOW write while disabled loads ACTIVE directly.
- R4: A selected event with a valid shadow address (and, in slow mode, with the channel armed) swaps buffers. On the next cycle ACTIVE holds the old shadow address, the word index is 0, STATUS bits 0 and 1 are clear, and `irq` is high for exactly one cycle.
- R5: CTRL bit 1 selects the event source: 0 selects `time_tick` and 1 selects `spin_pulse`. A pulse on the source that is not selected causes no swap and no interrupt.
- R6: A selected event with no valid shadow address causes no swap and no interrupt. Writing continues in the same buffer, and STATUS bit 2 (overrun) is set and stays set. Writing STATUS with bit 2 set clears it.
- R7: When CTRL bit 2 (slow) is set, an event swaps only if an ARM write with bit 0 set has been made before it. ARM sets STATUS bit 1. An event on an unarmed slow channel changes nothing, and it does not set overrun either.
- R8: Once the buffer holds BUF_BYTES/4 words, further valid words are not written. They are counted in DROPS. A swap resets DROPS to 0.
- R9: After a swap, LAST_BYTES holds the number of bytes written into the finished buffer. A word written in the same cycle as the swap event counts toward the finished buffer.
- R10: A CTRL write updates bit 1 only when the channel is disabled before that write. A write made while the channel is enabled leaves the selected source unchanged.
- R11: While the channel is disabled (CTRL bit 0 clear), input words are not written and events cause no swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational) |
| time_tick | input | 1 | Time synchronisation pulse |
| spin_pulse | input | 1 | Spin-phase synchronisation pulse |
| din_valid | input | 1 | Input word valid |
| din_data | input | DATA_W | Input word |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | One-cycle buffer-swap interrupt |

## Verification
The memory write outputs and `host_rdata` are combinational and due in the same cycle as their stimulus. `irq` and the new ACTIVE, STATUS, LAST_BYTES and DROPS values become visible one edge after the event or write that causes them. The bench changes every input on the falling clock edge and samples 1 ns later. A write check therefore sees the same-cycle result. A swap is checked in the step after its event, which lands on the single cycle in which `irq` is high. Register reads follow only after an idle step, so each registered effect has settled before it is read.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

    localparam int HOST_W = 32;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_SHADOW = 3'd1,
        REG_ARM    = 3'd2,
        REG_STATUS = 3'd3,
        REG_LAST   = 3'd4,
        REG_DROPS  = 3'd5,
        REG_ACTIVE = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic slow;
        logic sel;
        logic en;
    } chan_ctrl_t;

    typedef struct packed {
        logic overrun;
        logic armed;
        logic valid;
    } chan_stat_t;

    typedef struct packed {
        logic shadow_wr;
        logic arm_wr;
        logic ovr_clr;
        logic restart;
    } host_strobe_t;

    function automatic logic sync_event(input logic sel, input logic tick, input logic spin);
        return sel ? spin : tick;
    endfunction

endpackage

// File: rtl/pdc_ctrl_regs.sv
module pdc_ctrl_regs
    import pkt_dma_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         host_wr,
    input  logic [2:0]   host_addr,
    input  logic [2:0]   wbits,
    output chan_ctrl_t   ctrl,
    output host_strobe_t stb
);
    logic ctrl_wr;
    assign ctrl_wr = host_wr && (host_addr == REG_CTRL);

    always_comb begin
        stb.shadow_wr = host_wr && (host_addr == REG_SHADOW);
        stb.arm_wr    = host_wr && (host_addr == REG_ARM) && wbits[0];
        stb.ovr_clr   = host_wr && (host_addr == REG_STATUS) && wbits[2];
        stb.restart   = ctrl_wr && wbits[0] && !ctrl.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.en   <= wbits[0];
            ctrl.slow <= wbits[2];
            if (!ctrl.en)
                ctrl.sel <= wbits[1];
        end
    end

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && $past(ctrl.en)) |-> $stable(ctrl.sel)); // R10

endmodule

// File: rtl/pdc_addr_bank.sv
module pdc_addr_bank
    import pkt_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_ctrl_t        ctrl,
    input  host_strobe_t      stb,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              time_tick,
    input  logic              spin_pulse,
    output logic [ADDR_W-1:0] active,
    output chan_stat_t        stat,
    output logic              swap,
    output logic              irq
);
    logic [ADDR_W-1:0] shadow;
    logic              evt, allowed, miss;

    always_comb begin
        evt     = ctrl.en && sync_event(ctrl.sel, time_tick, spin_pulse);
        allowed = evt && (!ctrl.slow || stat.armed);
        swap    = allowed && stat.valid;
        miss    = allowed && !stat.valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
            shadow <= '0;
            stat   <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= swap;
            if (swap)
                active <= shadow;
            else if (stb.shadow_wr && !ctrl.en)
                active <= wdata;

            if (stb.shadow_wr && ctrl.en) begin
                shadow     <= wdata;
                stat.valid <= 1'b1;
            end else if (swap) begin
                stat.valid <= 1'b0;
            end

            if (stb.arm_wr)
                stat.armed <= 1'b1;
            else if (swap)
                stat.armed <= 1'b0;

            if (miss)
                stat.overrun <= 1'b1;
            else if (stb.ovr_clr)
                stat.overrun <= 1'b0;
        end
    end

    AST_IRQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(time_tick || spin_pulse)); // R4
    AST_SWAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(stb.shadow_wr) && !$past(stb.arm_wr)) |-> (!stat.valid && !stat.armed)); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(stat.overrun) && !$past(stb.ovr_clr)) |-> stat.overrun); // R6
    AST_SLOW_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(ctrl.slow)) |-> $past(stat.armed)); // R7

endmodule

// File: rtl/pdc_wr_engine.sv
module pdc_wr_engine #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BUF_BYTES = 4096,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              restart,
    input  logic              swap,
    input  logic              din_valid,
    input  logic [DATA_W-1:0] din_data,
    input  logic [ADDR_W-1:0] active,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [31:0]       last_bytes,
    output logic [31:0]       drops
);
    localparam int BPW    = DATA_W / 8;
    localparam int WORDS  = BUF_BYTES / BPW;
    localparam int PTR_W  = $clog2(WORDS + 1);
    localparam int OFS_W  = $clog2(BPW);
    localparam int BYTE_W = PTR_W + OFS_W;

    logic [PTR_W-1:0]  ptr;
    logic [DROP_W-1:0] drop_cnt;
    logic [BYTE_W-1:0] last_q;
    logic              full, accept, reject;

    always_comb begin
        full      = (ptr == PTR_W'(WORDS));
        accept    = en && din_valid && !full;
        reject    = en && din_valid && full;
        mem_we    = accept;
        mem_addr  = active + (ADDR_W'(ptr) << OFS_W);
        mem_wdata = din_data;
    end

    assign last_bytes = 32'(last_q);
    assign drops      = 32'(drop_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            drop_cnt <= '0;
            last_q   <= '0;
        end else if (swap) begin
            last_q   <= BYTE_W'(ptr + PTR_W'(accept)) << OFS_W;
            ptr      <= '0;
            drop_cnt <= '0;
        end else if (restart) begin
            ptr      <= '0;
            drop_cnt <= '0;
        end else begin
            if (accept)
                ptr <= ptr + 1'b1;
            if (reject && (drop_cnt != '1))
                drop_cnt <= drop_cnt + 1'b1;
        end
    end

    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        ((drop_cnt != $past(drop_cnt)) && !$past(swap) && !$past(restart))
        |-> ($past(ptr) == PTR_W'(WORDS))); // R8

endmodule

// File: rtl/pkt_dma_chan.sv
module pkt_dma_chan
    import pkt_dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BUF_BYTES = 4096,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              time_tick,
    input  logic              spin_pulse,
    input  logic              din_valid,
    input  logic [DATA_W-1:0] din_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq
);
    chan_ctrl_t        ctrl;
    chan_stat_t        stat;
    host_strobe_t      stb;
    logic [ADDR_W-1:0] active;
    logic              swap;
    logic [31:0]       last_bytes, drops;

    pdc_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .wbits     (host_wdata[2:0]),
        .ctrl      (ctrl),
        .stb       (stb)
    );

    pdc_addr_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .stb        (stb),
        .wdata      (host_wdata[ADDR_W-1:0]),
        .time_tick  (time_tick),
        .spin_pulse (spin_pulse),
        .active     (active),
        .stat       (stat),
        .swap       (swap),
        .irq        (irq)
    );

    pdc_wr_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BUF_BYTES (BUF_BYTES),
        .DROP_W    (DROP_W)
    ) u_wr (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl.en),
        .restart    (stb.restart),
        .swap       (swap),
        .din_valid  (din_valid),
        .din_data   (din_data),
        .active     (active),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .last_bytes (last_bytes),
        .drops      (drops)
    );

    always_comb begin
        case (host_addr)
            REG_CTRL:   host_rdata = HOST_W'(ctrl);
            REG_STATUS: host_rdata = HOST_W'(stat);
            REG_LAST:   host_rdata = last_bytes;
            REG_DROPS:  host_rdata = drops;
            REG_ACTIVE: host_rdata = HOST_W'(active);
            default:    host_rdata = '0;
        endcase
    end

    AST_ADDR_IN_BUF: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_addr - active) < ADDR_W'(BUF_BYTES))); // R2
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> (!mem_we && !swap)); // R11

endmodule

// File: tb/test_pkt_dma_chan.sv
module test_pkt_dma_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        time_tick = 1'b0;
    logic        spin_pulse = 1'b0;
    logic        din_valid = 1'b0;
    logic [31:0] din_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic        s_we, s_irq;
    logic [31:0] s_addr, s_wd, rv;

    // [20] valid [19] tick [18] spin [17] exp we [16] exp irq [15:0] exp addr
    localparam logic [20:0] VEC [11] = '{
        21'h121000, 21'h000000, 21'h121004, 21'h161008, 21'h12100C, 21'h1A1010,
        21'h132000, 21'h000000, 21'h122004, 21'h1A2008, 21'h12200C
    };

    always #2.5 clk = ~clk;

    pkt_dma_chan #(.BUF_BYTES(32)) i_pkt_dma_chan (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .time_tick(time_tick),
        .spin_pulse(spin_pulse), .din_valid(din_valid), .din_data(din_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic dv, input logic [31:0] d, input logic tk, input logic sp);
        @(negedge clk);
        host_wr = 1'b0; din_valid = dv; din_data = d; time_tick = tk; spin_pulse = sp;
        #1;
        s_we = mem_we; s_addr = mem_addr; s_wd = mem_wdata; s_irq = irq;
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        din_valid = 1'b0; time_tick = 1'b0; spin_pulse = 1'b0;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b0; din_valid = 1'b0; time_tick = 1'b0; spin_pulse = 1'b0;
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R11: reset state, disabled channel ignores input
        step(1'b1, 32'hBEEF, 1'b0, 1'b0);
        check("R1 we after reset", 32'(s_we), 0);
        check("R1 irq after reset", 32'(s_irq), 0);
        hread(3'd0, rv); check("R1 CTRL", rv, 0);
        hread(3'd3, rv); check("R1 STATUS", rv, 0);
        hread(3'd6, rv); check("R1 ACTIVE", rv, 0);

        // R3: direct load while disabled, then enable (time source)
        hwrite(3'd1, 32'h1000);
        hread(3'd6, rv); check("R3 ACTIVE direct load", rv, 32'h1000);
        hwrite(3'd0, 32'h1);
        hwrite(3'd1, 32'h2000);
        hread(3'd3, rv); check("R3 STATUS valid", rv, 32'h1);
        hread(3'd6, rv); check("R3 ACTIVE unchanged", rv, 32'h1000);

        // R2 R4 R5 R6: vector table
        for (int i = 0; i < 11; i++) begin
            step(VEC[i][20], 32'hD000 + 32'(i), VEC[i][19], VEC[i][18]);
            check($sformatf("R2 we row %0d", i), 32'(s_we), 32'(VEC[i][17]));
            if (VEC[i][17]) begin
                check($sformatf("R2 addr row %0d", i), s_addr, 32'(VEC[i][15:0]));
                check($sformatf("R2 data row %0d", i), s_wd, 32'hD000 + 32'(i));
            end
            check($sformatf("R4 R5 R6 irq row %0d", i), 32'(s_irq), 32'(VEC[i][16]));
        end
        hread(3'd4, rv); check("R9 LAST_BYTES", rv, 32'd20);
        hread(3'd6, rv); check("R4 ACTIVE after swap", rv, 32'h2000);
        hread(3'd3, rv); check("R6 STATUS overrun set", rv, 32'h4);
        hwrite(3'd3, 32'h4);
        hread(3'd3, rv); check("R6 overrun cleared", rv, 32'h0);

        // R10: source select ignored while enabled
        hwrite(3'd0, 32'h3);
        hread(3'd0, rv); check("R10 CTRL sel held", rv, 32'h1);
        hwrite(3'd1, 32'h2800);
        step(1'b0, 0, 1'b0, 1'b1);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R10 spin ignored irq", 32'(s_irq), 0);
        hread(3'd6, rv); check("R10 ACTIVE unchanged", rv, 32'h2000);

        // R7: slow channel needs arm
        hwrite(3'd0, 32'h0);
        hwrite(3'd0, 32'h5);
        hwrite(3'd1, 32'h3000);
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R7 unarmed irq", 32'(s_irq), 0);
        hread(3'd3, rv); check("R7 unarmed STATUS", rv, 32'h1);
        hwrite(3'd2, 32'h1);
        hread(3'd3, rv); check("R7 armed STATUS", rv, 32'h3);
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R7 armed irq", 32'(s_irq), 1);
        hread(3'd3, rv); check("R4 STATUS cleared", rv, 32'h0);
        hread(3'd6, rv); check("R7 ACTIVE", rv, 32'h3000);

        // R8: full buffer drops words
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 32'hE000 + 32'(i), 1'b0, 1'b0);
            check($sformatf("R8 we word %0d", i), 32'(s_we), (i < 8) ? 32'd1 : 32'd0);
            if (i < 8) check($sformatf("R8 addr word %0d", i), s_addr, 32'h3000 + 32'(4 * i));
        end
        hread(3'd5, rv); check("R8 DROPS", rv, 32'd2);
        hwrite(3'd1, 32'h4000);
        hwrite(3'd2, 32'h1);
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R8 swap irq", 32'(s_irq), 1);
        hread(3'd4, rv); check("R9 LAST_BYTES full", rv, 32'd32);
        hread(3'd5, rv); check("R8 DROPS reset", rv, 32'd0);

        // R11: disabled channel
        hwrite(3'd0, 32'h0);
        hwrite(3'd1, 32'h6000);
        hread(3'd6, rv); check("R3 ACTIVE direct load 2", rv, 32'h6000);
        step(1'b1, 32'h77, 1'b1, 1'b0);
        check("R11 disabled we", 32'(s_we), 0);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R11 disabled irq", 32'(s_irq), 0);

        // R5 R10: spin source selected from disabled state
        hwrite(3'd0, 32'h3);
        hread(3'd0, rv); check("R10 CTRL sel taken", rv, 32'h3);
        hwrite(3'd1, 32'h5000);
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R5 tick ignored", 32'(s_irq), 0);
        step(1'b0, 0, 1'b0, 1'b1);
        step(1'b0, 0, 1'b0, 1'b0);
        check("R5 spin swap irq", 32'(s_irq), 1);
        step(1'b1, 32'h99, 1'b0, 1'b0);
        check("R4 irq one cycle", 32'(s_irq), 0);
        check("R2 restart addr", s_addr, 32'h5000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule